// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block classifies every processor memory access that falls in the legacy window between 0xA0000 and 0xFFFFF. For each access it says where the access should go: to system RAM with normal read and write behaviour, to RAM as a dropped write (the segment is read-only shadow memory), or out to the expansion bus. Software programs the policy through a byte-wide register write port. A system-management-mode (SMM) level input also takes part in the decision.

The window 0xC0000–0xFFFFF is divided into sixteen 16 KB pages. The lower twelve pages (0xC0000–0xEFFFF) each have their own 2-bit attribute field. The top four pages (0xF0000–0xFFFFF) share one field. The video window 0xA0000–0xBFFFF is governed by a control register. That register has an "open" bit, which maps the window to RAM unconditionally. It also has an "SMM enable" bit, which maps the window to RAM only while the SMM input is high. The decision is combinational in the access address, the read/write flag and the SMM input. Register writes take effect on the clock edge that captures them.

Top module: `legacy_mem_decode`

## Requirements
- R1: An access outside 0xA0000–0xFFFFF, including any address with a bit above bit 19 set, reports `route_o = 2'b01` (RAM) for both reads and writes.
- R2: The 64 KB range 0xF0000–0xFFFFF takes its attribute from bits [5:4] of the register at address 0x59.
- R3: Page i (0..11) at 0xC0000 + i×0x4000 takes its attribute from the register at 0x5A + (i>>1). Even pages use bits [1:0] and odd pages use bits [5:4].
- R4: Attribute value 3 gives `route_o = 2'b01` (RAM) for reads and for writes.
- R5: Attribute value 1 gives `2'b01` for a read (`acc_write_i = 0`) and `2'b10` (write dropped) for a write (`acc_write_i = 1`). The code `2'b10` never appears for a read.
- R6: Attribute values 0 and 2 give `route_o = 2'b00` (expansion bus) for both directions.
- R7: An access in 0xA0000–0xBFFFF gives `2'b01` when bit 6 of register 0x72 is set, or when bit 3 of register 0x72 is set while `smm_i` is high. Otherwise it gives `2'b00`.
- R8: After reset, register 0x72 holds 0x02 and registers 0x59–0x5F hold 0x00. So every shadow page and the video window route to the bus, even with `smm_i` high.
- R9: A register write presented in a cycle has no effect on `route_o` until the rising clock edge that captures it. After that edge it applies at once. A change of `smm_i` changes `route_o` in the same cycle, with no clock edge needed.
- R10: Writes with `cfg_we_i` low, and writes to addresses other than 0x59–0x5F and 0x72 (for example 0x58, 0x60, 0x71, 0x73), change no routing decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte address |
| cfg_data_i | input | 8 | Register write data |
| smm_i | input | 1 | System-management-mode level |
| acc_addr_i | input | ADDR_W (32) | Processor access address |
| acc_write_i | input | 1 | 1 = write access, 0 = read |
| route_o | output | 2 | 00 bus, 01 RAM, 10 write dropped |

## Verification
The hardest condition to reach from the ports is a video-window access where the SMM enable bit alone decides the outcome. This needs the open bit clear, the SMM enable bit set, and the SMM input changing between accesses with no register write in between. Purely random register traffic reaches it only rarely. A directed sequence therefore programs 0x72 to 0x08 and toggles `smm_i` within single cycles. Random stimulus then mixes SMM toggles with writes that land on and just beside the live register addresses. A bench model compares each decision in the cycle the access is presented.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    typedef enum logic [1:0] {
        ROUTE_BUS  = 2'b00,
        ROUTE_RAM  = 2'b01,
        ROUTE_DROP = 2'b10
    } route_e;

    typedef enum logic [1:0] {
        AREA_OUTSIDE = 2'b00,
        AREA_VIDEO   = 2'b01,
        AREA_SHADOW  = 2'b10
    } area_e;

    localparam logic [1:0] ATTR_RO = 2'd1;
    localparam logic [1:0] ATTR_RW = 2'd3;

    localparam int CTRL_OPEN_BIT   = 6;
    localparam int CTRL_SMMEN_BIT  = 3;
    localparam int PAGE_SHIFT      = 14;

endpackage

// File: rtl/lmd_cfg_regs.sv
module lmd_cfg_regs #(
    parameter int          REG_AW      = 8,
    parameter int          SHADOW_CNT  = 7,
    parameter logic [7:0]  SHADOW_BASE = 8'h59,
    parameter logic [7:0]  CTRL_ADDR   = 8'h72,
    parameter logic [7:0]  CTRL_RST    = 8'h02
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    we_i,
    input  logic [REG_AW-1:0]       addr_i,
    input  logic [7:0]              data_i,
    output logic [SHADOW_CNT*8-1:0] shadow_o,
    output logic [7:0]              ctrl_o
);

    for (genvar g = 0; g < SHADOW_CNT; g++) begin : g_shadow
        localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(SHADOW_BASE) + REG_AW'(g);
        logic [7:0] byte_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                byte_q <= 8'h00;
            end else if (we_i && (addr_i == MY_ADDR)) begin
                byte_q <= data_i;
            end
        end

        assign shadow_o[g*8 +: 8] = byte_q;
    end

    logic [7:0] ctrl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= CTRL_RST;
        end else if (we_i && (addr_i == REG_AW'(CTRL_ADDR))) begin
            ctrl_q <= data_i;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/lmd_region_decode.sv
module lmd_region_decode
    import lmd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:PAGE_SHIFT] page_i,
    output area_e                      area_o,
    output logic [3:0]                 page_idx_o
);

    localparam int LOW_TOP = 20;

    logic above_1m;
    assign above_1m = |page_i[ADDR_W-1:LOW_TOP];

    always_comb begin
        area_o = AREA_OUTSIDE;
        if (!above_1m) begin
            unique case (page_i[19:17])
                3'b101:         area_o = AREA_VIDEO;
                3'b110, 3'b111: area_o = AREA_SHADOW;
                default:        area_o = AREA_OUTSIDE;
            endcase
        end
    end

    assign page_idx_o = page_i[17:14];

endmodule

// File: rtl/lmd_route_sel.sv
module lmd_route_sel
    import lmd_pkg::*;
#(
    parameter int SHADOW_CNT = 7,
    parameter int SEG_CNT    = 12
) (
    input  area_e                   area_i,
    input  logic [3:0]              page_idx_i,
    input  logic [SHADOW_CNT*8-1:0] shadow_i,
    input  logic                    win_open_i,
    input  logic                    win_smm_en_i,
    input  logic                    smm_i,
    input  logic                    write_i,
    output route_e                  route_o
);

    int         sel;
    logic [1:0] attr;

    always_comb begin
        if (int'(page_idx_i) >= SEG_CNT) begin
            sel = 4;
        end else begin
            sel = (1 + int'(page_idx_i >> 1)) * 8 + int'(page_idx_i[0]) * 4;
        end
        attr = shadow_i[sel +: 2];
    end

    always_comb begin
        route_o = ROUTE_RAM;
        unique case (area_i)
            AREA_VIDEO: begin
                route_o = (win_open_i || (smm_i && win_smm_en_i)) ? ROUTE_RAM : ROUTE_BUS;
            end
            AREA_SHADOW: begin
                if (attr == ATTR_RW) begin
                    route_o = ROUTE_RAM;
                end else if (attr == ATTR_RO) begin
                    route_o = write_i ? ROUTE_DROP : ROUTE_RAM;
                end else begin
                    route_o = ROUTE_BUS;
                end
            end
            default: route_o = ROUTE_RAM;
        endcase
    end

endmodule

// File: rtl/legacy_mem_decode.sv
module legacy_mem_decode
    import lmd_pkg::*;
#(
    parameter int         ADDR_W      = 32,
    parameter int         SHADOW_CNT  = 7,
    parameter int         SEG_CNT     = 12,
    parameter logic [7:0] SHADOW_BASE = 8'h59,
    parameter logic [7:0] CTRL_ADDR   = 8'h72,
    parameter logic [7:0] CTRL_RST    = 8'h02
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cfg_we_i,
    input  logic [7:0]        cfg_addr_i,
    input  logic [7:0]        cfg_data_i,
    input  logic              smm_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              acc_write_i,
    output logic [1:0]        route_o
);

    logic [SHADOW_CNT*8-1:0] shadow_w;
    logic [7:0]              ctrl_w;
    area_e                   area_w;
    logic [3:0]              page_idx_w;
    route_e                  route_w;

    lmd_cfg_regs #(
        .REG_AW      (8),
        .SHADOW_CNT  (SHADOW_CNT),
        .SHADOW_BASE (SHADOW_BASE),
        .CTRL_ADDR   (CTRL_ADDR),
        .CTRL_RST    (CTRL_RST)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .we_i     (cfg_we_i),
        .addr_i   (cfg_addr_i),
        .data_i   (cfg_data_i),
        .shadow_o (shadow_w),
        .ctrl_o   (ctrl_w)
    );

    lmd_region_decode #(
        .ADDR_W (ADDR_W)
    ) u_region (
        .page_i     (acc_addr_i[ADDR_W-1:PAGE_SHIFT]),
        .area_o     (area_w),
        .page_idx_o (page_idx_w)
    );

    lmd_route_sel #(
        .SHADOW_CNT (SHADOW_CNT),
        .SEG_CNT    (SEG_CNT)
    ) u_sel (
        .area_i       (area_w),
        .page_idx_i   (page_idx_w),
        .shadow_i     (shadow_w),
        .win_open_i   (ctrl_w[CTRL_OPEN_BIT]),
        .win_smm_en_i (ctrl_w[CTRL_SMMEN_BIT]),
        .smm_i        (smm_i),
        .write_i      (acc_write_i),
        .route_o      (route_w)
    );

    assign route_o = route_w;

endmodule

// File: rtl/legacy_mem_decode_checker.sv
module legacy_mem_decode_checker #(
    parameter int         ADDR_W      = 32,
    parameter int         SHADOW_CNT  = 7,
    parameter logic [7:0] SHADOW_BASE = 8'h59,
    parameter logic [7:0] CTRL_ADDR   = 8'h72,
    parameter logic [7:0] CTRL_RST    = 8'h02
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    cfg_we_i,
    input logic [7:0]              cfg_addr_i,
    input logic                    smm_i,
    input logic [ADDR_W-1:0]       acc_addr_i,
    input logic                    acc_write_i,
    input logic [1:0]              route_o,
    input logic [SHADOW_CNT*8-1:0] shadow_w,
    input logic [7:0]              ctrl_w
);

    logic outside, in_video, live_write;

    always_comb begin
        outside  = (acc_addr_i < ADDR_W'(32'h000A_0000)) || (acc_addr_i > ADDR_W'(32'h000F_FFFF));
        in_video = (acc_addr_i >= ADDR_W'(32'h000A_0000)) && (acc_addr_i < ADDR_W'(32'h000C_0000));
        live_write = cfg_we_i && ((cfg_addr_i == CTRL_ADDR) ||
                     ((cfg_addr_i >= SHADOW_BASE) && (cfg_addr_i < SHADOW_BASE + 8'(SHADOW_CNT))));
    end

    // R1
    p_outside_ram_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        outside |-> (route_o == 2'b01));

    // R5
    p_drop_write_only_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (route_o == 2'b10) |-> acc_write_i);

    // R7
    p_video_window_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        in_video |-> (route_o == ((ctrl_w[6] || (smm_i && ctrl_w[3])) ? 2'b01 : 2'b00)));

    // R8
    p_reset_values_r8: assert property (@(posedge clk_i)
        rst_i |=> ((ctrl_w == CTRL_RST) && (shadow_w == '0)));

    // R10
    p_ignored_write_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !live_write |=> ($stable(shadow_w) && $stable(ctrl_w)));

endmodule

bind legacy_mem_decode legacy_mem_decode_checker #(
    .ADDR_W      (ADDR_W),
    .SHADOW_CNT  (SHADOW_CNT),
    .SHADOW_BASE (SHADOW_BASE),
    .CTRL_ADDR   (CTRL_ADDR),
    .CTRL_RST    (CTRL_RST)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .smm_i       (smm_i),
    .acc_addr_i  (acc_addr_i),
    .acc_write_i (acc_write_i),
    .route_o     (route_o),
    .shadow_w    (shadow_w),
    .ctrl_w      (ctrl_w)
);

// File: tb/legacy_mem_decode_bench.sv
`timescale 1ns/1ps
module legacy_mem_decode_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_data;
    logic        smm;
    logic [31:0] acc_addr;
    logic        acc_write;
    logic [1:0]  route;

    int tests = 0;
    int fails = 0;
    logic [7:0] mreg [0:255];

    always #10 clk = ~clk;

    legacy_mem_decode u_legacy_mem_decode (
        .clk_i (clk), .rst_i (rst), .cfg_we_i (cfg_we), .cfg_addr_i (cfg_addr),
        .cfg_data_i (cfg_data), .smm_i (smm), .acc_addr_i (acc_addr),
        .acc_write_i (acc_write), .route_o (route)
    );

    function automatic logic [1:0] exp_route(input logic [31:0] a, input logic wr, input logic s);
        logic [1:0] at;
        int idx;
        if (a < 32'hA0000 || a > 32'hFFFFF) return 2'b01;
        if (a < 32'hC0000) return (mreg[8'h72][6] || (s && mreg[8'h72][3])) ? 2'b01 : 2'b00;
        if (a >= 32'hF0000) begin
            at = mreg[8'h59][5:4];
        end else begin
            idx = int'((a - 32'hC0000) / 32'h4000);
            at = 2'((mreg[8'h5A + idx / 2] >> ((idx % 2) * 4)) & 8'h3);
        end
        if (at == 2'd3) return 2'b01;
        if (at == 2'd1) return wr ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) mreg[i] = 8'h00;
        mreg[8'h72] = 8'h02;
    endtask

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h wr=%0d smm=%0d actual=%b expected=%b",
                     req, acc_addr, acc_write, smm, act, exp);
        end
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic wr);
        @(negedge clk);
        acc_addr = a; acc_write = wr;
        #1 check(req, route, exp_route(a, wr, smm));
    endtask

    task automatic wreg(input logic [7:0] ad, input logic [7:0] d, input logic en);
        @(negedge clk);
        cfg_we = en; cfg_addr = ad; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (en && ((ad >= 8'h59 && ad <= 8'h5F) || ad == 8'h72)) mreg[ad] = d;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = 8'h00; cfg_data = 8'h00;
        smm = 1'b0; acc_addr = 32'h0; acc_write = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: reset state
        smm = 1'b1;
        access("R8 video bus after reset", 32'hA8000, 1'b0);
        access("R8 top page bus after reset", 32'hF1234, 1'b1);
        access("R8 page bus after reset", 32'hC4000, 1'b0);
        smm = 1'b0;
        // R1: outside
        access("R1 low memory", 32'h0009FFFF, 1'b1);
        access("R1 above 1MB", 32'h00100000, 1'b0);
        access("R1 high bits", 32'h800F0000, 1'b1);

        // R2/R4: top range read-write
        wreg(8'h59, 8'h30, 1'b1);
        access("R2 R4 top write", 32'hFFFFF, 1'b1);
        access("R2 R4 top read", 32'hF0000, 1'b0);
        // R5: read only
        wreg(8'h59, 8'h13, 1'b1);
        access("R5 top read", 32'hF8000, 1'b0);
        access("R5 top write dropped", 32'hF8000, 1'b1);

        // R3: page 5 uses 0x5C bits[5:4], page 4 the low bits
        wreg(8'h5C, 8'h10, 1'b1);
        access("R3 page5 write", 32'hD4000, 1'b1);
        access("R3 page4 bus", 32'hD0000, 1'b1);
        wreg(8'h5F, 8'h23, 1'b1);
        access("R3 R4 page10", 32'hE8000, 1'b1);
        access("R3 R6 page11 attr2", 32'hEFFFF, 1'b0);

        // R9: no effect before the capturing edge
        @(negedge clk);
        acc_addr = 32'hC0000; acc_write = 1'b0;
        cfg_we = 1'b1; cfg_addr = 8'h5A; cfg_data = 8'h03;
        #1 check("R9 before edge", route, 2'b00);
        @(negedge clk);
        cfg_we = 1'b0; mreg[8'h5A] = 8'h03;
        #1 check("R9 after edge", route, 2'b01);

        // R7/R9: SMM gated window
        wreg(8'h72, 8'h08, 1'b1);
        @(negedge clk);
        acc_addr = 32'hB0000; acc_write = 1'b1; smm = 1'b0;
        #1 check("R7 smm low bus", route, 2'b00);
        #2 smm = 1'b1;
        #1 check("R7 R9 smm high ram same cycle", route, 2'b01);
        #2 smm = 1'b0;
        #1 check("R7 R9 smm drop back", route, 2'b00);
        wreg(8'h72, 8'h40, 1'b1);
        access("R7 open bit", 32'hA0000, 1'b0);

        // R10: ignored writes
        wreg(8'h72, 8'h02, 1'b1);
        wreg(8'h59, 8'h00, 1'b1);
        wreg(8'h59, 8'h30, 1'b0);
        access("R10 we low", 32'hF0000, 1'b0);
        wreg(8'h58, 8'hFF, 1'b1);
        wreg(8'h60, 8'hFF, 1'b1);
        wreg(8'h71, 8'hFF, 1'b1);
        wreg(8'h73, 8'hFF, 1'b1);
        access("R10 neighbours top", 32'hF0000, 1'b1);
        smm = 1'b1;
        access("R10 neighbours video", 32'hA0000, 1'b0);
        smm = 1'b0;

        // Random mix: R1..R7, R10
        for (int n = 0; n < 500; n++) begin
            logic [7:0] ra;
            ra = ($urandom % 2) ? (8'h58 + 8'($urandom % 9)) : (8'h71 + 8'($urandom % 3));
            wreg(ra, 8'($urandom), 1'($urandom % 4 != 0));
            for (int k = 0; k < 4; k++) begin
                logic [31:0] a;
                if ($urandom % 8 == 0) a = $urandom;
                else a = 32'h98000 + ($urandom % 32'h70000);
                smm = 1'($urandom);
                access("R1-7 R10 random", a, 1'($urandom));
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule